// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a free-running watchdog counter that advances on a low-speed clock tick and has no stop control. If software lets the counter reach the end of its period without servicing it, the block first raises a one-cycle non-maskable interrupt request. This gives the handler one more full period to recover. If the next period also ends without service, the block raises a system reset request. That request stays high until the block itself is reset.

Software services the watchdog by writing a two-byte key through a simple write port: the arm byte 0x5A, then the fire byte 0xA5. A completed key restarts the count from zero and forgets a pending first overflow. The overflow period is one of four lengths, chosen by a 2-bit select, and each length is four times the previous one. At a 32 kHz tick the default lengths are 4096, 16384, 65536 and 262144 ticks, which is roughly 125 ms, 500 ms, 2 s and 8 s. The select is sampled only when the count restarts, so a change made in the middle of a count waits for the next clear or reset.

Top module: `wdt_two_stage`

## Requirements
- R1: While rst is high and in the first cycle after it falls, nmi_req and rst_req are 0, and the count starts from zero.
- R2: With period_sel value s latched, the period is 2^(BASE_LOG2+2*s) ticks. nmi_req is 1 for exactly one cycle, in the cycle after the clock edge that accepts the final tick of a period when no earlier overflow is pending.
- R3: Only cycles with tick high advance the count. Cycles with tick low never produce nmi_req, and they never change rst_req.
- R4: An overflow while a first overflow is pending sets rst_req. rst_req then stays 1, whatever clears or ticks follow, until rst. No nmi_req is produced while rst_req is 1.
- R5: A valid clear is a write of 0x5A (arm) followed by a later write of 0xA5 (fire). Cycles without a write may fall between the two writes. The clear restarts the count from zero and drops a pending first overflow, so the next overflow gives nmi_req rather than rst_req.
- R6: A write of 0xA5 without a prior arm has no effect. A write of any value other than 0x5A or 0xA5 after an arm cancels the arm. A repeated 0x5A keeps the block armed.
- R7: period_sel is captured only during rst and on a valid clear. A change made while counting does not alter the current period.
- R8: A valid clear in the same cycle as the final tick of a period wins: no overflow is recorded, and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle low-speed clock tick enable |
| period_sel | input | 2 | Overflow period select, 0 shortest to 3 longest |
| wr_en | input | 1 | Key write strobe |
| wr_data | input | 8 | Key byte written |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| rst_req | output | 1 | Sticky system reset request |

## Verification
The hardest state to reach from the ports is the collision between a completed key and the final tick of a period. The stimulus reaches it by writing the arm byte on the next-to-last tick and the fire byte on the last tick, so the clear and the wrap compete at one clock edge. The cancelled and repeated key sequences are placed in the middle of a count. A clear that was wrongly taken, or wrongly missed, then moves the interrupt by a known number of ticks, and the quiet-window checks catch it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam logic [7:0] KEY_ARM  = 8'h5A;
    localparam logic [7:0] KEY_FIRE = 8'hA5;

    typedef enum logic {
        KEY_IDLE,
        KEY_ARMED
    } key_state_e;

    typedef enum logic [1:0] {
        ESC_QUIET,
        ESC_WARNED,
        ESC_TRIPPED
    } esc_state_e;

    // Last count value of a period: 2^(base + 2*sel) - 1
    function automatic int unsigned period_last(input int unsigned base, input logic [1:0] sel);
        return (32'd1 << (base + 2 * int'(sel))) - 32'd1;
    endfunction

endpackage

// File: rtl/wdt_key_unlock.sv
module wdt_key_unlock
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       clr
);
    key_state_e st_q;
    key_state_e st_d;

    always_comb begin
        st_d = st_q;
        clr  = 1'b0;
        if (wr_en) begin
            if (wr_data == KEY_ARM) begin
                st_d = KEY_ARMED;
            end else if (wr_data == KEY_FIRE && st_q == KEY_ARMED) begin
                st_d = KEY_IDLE;
                clr  = 1'b1;
            end else begin
                st_d = KEY_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= KEY_IDLE;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 12,
    localparam int unsigned CNT_W    = BASE_LOG2 + 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clr,
    input  logic [1:0]       period_sel,
    output logic             ovf,
    output logic [CNT_W-1:0] cnt,
    output logic [1:0]       sel_latched
);
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       sel_q;
    logic [CNT_W-1:0] last;
    logic             at_end;

    assign last   = CNT_W'(period_last(BASE_LOG2, sel_q));
    assign at_end = (cnt_q == last);
    assign ovf    = tick && !clr && at_end;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            sel_q <= period_sel;
        end else if (tick) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end

    assign cnt         = cnt_q;
    assign sel_latched = sel_q;
endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ovf,
    input  logic clr,
    output logic nmi_req,
    output logic rst_req,
    output logic warned
);
    esc_state_e esc_q;
    logic       nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            esc_q <= ESC_QUIET;
            nmi_q <= 1'b0;
        end else begin
            nmi_q <= 1'b0;
            if (ovf) begin
                case (esc_q)
                    ESC_QUIET: begin
                        esc_q <= ESC_WARNED;
                        nmi_q <= 1'b1;
                    end
                    ESC_WARNED: esc_q <= ESC_TRIPPED;
                    default:    esc_q <= ESC_TRIPPED;
                endcase
            end else if (clr && esc_q == ESC_WARNED) begin
                esc_q <= ESC_QUIET;
            end
        end
    end

    assign nmi_req = nmi_q;
    assign rst_req = (esc_q == ESC_TRIPPED);
    assign warned  = (esc_q == ESC_WARNED);
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 12,
    localparam int unsigned CNT_W    = BASE_LOG2 + 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [1:0] period_sel,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       nmi_req,
    output logic       rst_req
);
    logic             clr_hit;
    logic             ovf_hit;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       sel_q;
    logic             warned;

    wdt_key_unlock u_key (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .clr     (clr_hit)
    );

    wdt_counter #(.BASE_LOG2(BASE_LOG2)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .clr         (clr_hit),
        .period_sel  (period_sel),
        .ovf         (ovf_hit),
        .cnt         (cnt_q),
        .sel_latched (sel_q)
    );

    wdt_escalate u_esc (
        .clk     (clk),
        .rst     (rst),
        .ovf     (ovf_hit),
        .clr     (clr_hit),
        .nmi_req (nmi_req),
        .rst_req (rst_req),
        .warned  (warned)
    );
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
    parameter int unsigned CNT_W = 18
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             clr_hit,
    input logic [CNT_W-1:0] cnt_q,
    input logic [1:0]       sel_q,
    input logic             warned,
    input logic             nmi_req,
    input logic             rst_req
);
    p_nmi_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        nmi_req |=> !nmi_req);

    p_rst_hold_r4: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> rst_req);

    p_no_nmi_tripped_r4: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !nmi_req);

    p_idle_no_event_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> (!nmi_req && $stable(rst_req)));

    p_idle_cnt_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr_hit) |=> $stable(cnt_q));

    p_clear_drops_stage_r5: assert property (@(posedge clk) disable iff (rst)
        clr_hit |=> (!warned && cnt_q == '0));

    p_sel_held_r7: assert property (@(posedge clk) disable iff (rst)
        !clr_hit |=> $stable(sel_q));

    p_clear_wins_r8: assert property (@(posedge clk) disable iff (rst)
        clr_hit |=> (!nmi_req && !$rose(rst_req)));
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .clr_hit (clr_hit),
    .cnt_q   (cnt_q),
    .sel_q   (sel_q),
    .warned  (warned),
    .nmi_req (nmi_req),
    .rst_req (rst_req)
);

// File: tb/wdt_two_stage_bench.sv
module wdt_two_stage_bench;
    localparam int BASE = 4;
    localparam int NV   = 4;
    localparam logic [1:0] SEL_V [NV] = '{2'd2, 2'd0, 2'd3, 2'd1};
    localparam int         LEN_V [NV] = '{256, 16, 1024, 64};

    logic       clk = 1'b0;
    logic       rst, tick, wr_en;
    logic [7:0] wr_data;
    logic [1:0] period_sel;
    logic       nmi_req, rst_req;
    int         checks = 0;
    int         fails  = 0;
    bit         done   = 0;

    always #2 clk = ~clk;

    wdt_two_stage #(.BASE_LOG2(BASE)) u_wdt_two_stage (
        .clk(clk), .rst(rst), .tick(tick), .period_sel(period_sel),
        .wr_en(wr_en), .wr_data(wr_data), .nmi_req(nmi_req), .rst_req(rst_req)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic cyc(input logic t, input logic we, input logic [7:0] d);
        tick = t; wr_en = we; wr_data = d;
        @(negedge clk);
    endtask

    task automatic run_quiet(input int n, input string req);
        int seen = 0;
        for (int k = 0; k < n; k++) begin
            cyc(1'b1, 1'b0, 8'h00);
            if (nmi_req !== 1'b0) seen++;
        end
        check(req, seen != 0, 1'b0);
    endtask

    task automatic fire_tick(input string req);
        cyc(1'b1, 1'b0, 8'h00);
        check(req, nmi_req, 1'b1);
        cyc(1'b0, 1'b0, 8'h00);
        check(req, nmi_req, 1'b0);
    endtask

    task automatic key_clear();
        cyc(1'b0, 1'b1, 8'h5A);
        cyc(1'b0, 1'b1, 8'hA5);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cyc(1'b0, 1'b0, 8'h00);
        cyc(1'b0, 1'b0, 8'h00);
        rst = 1'b0;
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
        end
    end

    initial begin
        rst = 1'b1; tick = 1'b0; wr_en = 1'b0; wr_data = 8'h00; period_sel = 2'd0;
        @(negedge clk);
        cyc(1'b1, 1'b0, 8'h00);
        check("R1 nmi in reset", nmi_req, 1'b0);
        check("R1 rst_req in reset", rst_req, 1'b0);
        rst = 1'b0;
        cyc(1'b0, 1'b0, 8'h00);
        check("R1 rst_req after reset", rst_req, 1'b0);
        // R1: tick during reset must not count
        run_quiet(15, "R1 count from zero");
        fire_tick("R1 first overflow at 16");

        // R2 vector walk over all period selects
        for (int i = 0; i < NV; i++) begin
            period_sel = SEL_V[i];
            key_clear();
            run_quiet(LEN_V[i] - 1, "R2 quiet window");
            fire_tick("R2 overflow pulse");
            check("R2 no reset on first overflow", rst_req, 1'b0);
        end
        period_sel = 2'd0;

        // R3: idle cycles between ticks
        do_reset();
        for (int k = 0; k < 15; k++) begin
            cyc(1'b1, 1'b0, 8'h00);
            cyc(1'b0, 1'b0, 8'h00);
            cyc(1'b0, 1'b0, 8'h00);
        end
        check("R3 no nmi while gaps", nmi_req, 1'b0);
        fire_tick("R3 overflow on 16th tick");

        // R4: second overflow trips reset
        do_reset();
        run_quiet(15, "R4 first window");
        fire_tick("R4 first overflow nmi");
        run_quiet(15, "R4 second window");
        check("R4 rst_req not yet", rst_req, 1'b0);
        cyc(1'b1, 1'b0, 8'h00);
        check("R4 rst_req set", rst_req, 1'b1);
        check("R4 no nmi at second overflow", nmi_req, 1'b0);
        key_clear();
        check("R4 rst_req survives clear", rst_req, 1'b1);
        run_quiet(40, "R4 no nmi when tripped");
        check("R4 rst_req still held", rst_req, 1'b1);
        do_reset();
        check("R4 rst_req cleared by reset", rst_req, 1'b0);

        // R5: clear drops stage; gap between key bytes allowed
        run_quiet(15, "R5 window");
        fire_tick("R5 first nmi");
        run_quiet(10, "R5 partial");
        cyc(1'b0, 1'b1, 8'h5A);
        cyc(1'b0, 1'b0, 8'h00);
        cyc(1'b0, 1'b1, 8'hA5);
        run_quiet(15, "R5 restarted window");
        fire_tick("R5 nmi again not reset");
        check("R5 no reset after clear", rst_req, 1'b0);

        // R6: malformed keys ignored
        do_reset();
        run_quiet(8, "R6 pre");
        cyc(1'b0, 1'b1, 8'hA5);
        run_quiet(7, "R6 lone fire ignored");
        fire_tick("R6 lone fire no clear");
        key_clear();
        run_quiet(8, "R6 pre2");
        cyc(1'b0, 1'b1, 8'h5A);
        cyc(1'b0, 1'b1, 8'h33);
        cyc(1'b0, 1'b1, 8'hA5);
        run_quiet(7, "R6 cancelled key");
        fire_tick("R6 cancelled key no clear");
        key_clear();
        run_quiet(8, "R6 pre3");
        cyc(1'b0, 1'b1, 8'h5A);
        cyc(1'b0, 1'b1, 8'h5A);
        cyc(1'b0, 1'b1, 8'hA5);
        run_quiet(15, "R6 repeated arm clears");
        fire_tick("R6 repeated arm overflow at 16");

        // R7: select change waits for clear
        do_reset();
        period_sel = 2'd1;
        run_quiet(15, "R7 old period kept");
        fire_tick("R7 overflow at old period");
        key_clear();
        run_quiet(63, "R7 new period window");
        fire_tick("R7 overflow at new period");
        period_sel = 2'd0;

        // R8: clear on the final tick wins
        do_reset();
        run_quiet(14, "R8 pre");
        cyc(1'b1, 1'b1, 8'h5A);
        cyc(1'b1, 1'b1, 8'hA5);
        check("R8 no nmi on collision", nmi_req, 1'b0);
        run_quiet(15, "R8 restarted window");
        fire_tick("R8 overflow after restart");
        check("R8 no reset", rst_req, 1'b0);

        done = 1;
        report();
    end
endmodule